// File: doc/BRIEF.md
# Sequential Stream Buffer Prefetcher

This block is a small FIFO of prefetched cache blocks placed next to a direct-mapped cache. It keeps every prefetched block out of the cache until that block is referenced. When the cache misses, it presents the missing block index to the block. The block compares that index with the tag of the oldest FIFO entry only. On a match it returns that entry's data to the cache fill path and retires the entry. The freed slot then causes a fetch of the next sequential block from the next memory level. When the index does not match, the block reports a miss, drops every entry and starts a new stream at the block after the missing one.

Requests to the next level go out one at a time and complete in order. Each response fills the slot that was reserved when its request was issued. If a stream is abandoned while a request is still in flight, the response for that request is thrown away. A lookup that matches the head tag before the head's data has returned is held until the data lands.

Top module: `seq_stream_pf`

## Requirements
- R1: After reset, no memory request and no lookup completion are signalled until the first lookup arrives.
- R2: A lookup whose block index differs from the head tag, or that meets an empty buffer, completes with `lkp_done`=1 and `lkp_hit`=0. `lkp_done` is a single-cycle pulse and only follows a presented lookup.
- R3: After a miss on block b, the block requests b+1, b+2, … b+DEPTH in that order and then issues nothing more while no entry is consumed. Occupancy never exceeds DEPTH.
- R4: A lookup matching a head whose data is present completes one cycle later with `lkp_hit`=1 and `lkp_data` equal to the data the memory returned for that block index.
- R5: Each consumed head causes exactly one new request, for the block index one above the newest entry. This continues across pointer wrap.
- R6: A lookup that matches an entry other than the head counts as a miss and restarts the stream at that index plus one.
- R7: A lookup that matches the head tag while the head's data is still outstanding is held without completing. It completes as a hit with the correct data once the response arrives.
- R8: At most one memory request is outstanding. After a request is accepted, `mreq_valid` stays low until its response returns.
- R9: A response to a request issued for an abandoned stream never fills an entry. Later hits return only data of their own block index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lkp_valid | input | 1 | Cache miss lookup; held until `lkp_done`, dropped the cycle after |
| lkp_addr | input | ADDR_W | Missing block index |
| lkp_done | output | 1 | Lookup completed (one-cycle pulse) |
| lkp_hit | output | 1 | Completed lookup found the block at the head |
| lkp_data | output | DATA_W | Block data for a hit |
| mreq_valid | output | 1 | Prefetch request to the next memory level |
| mreq_ready | input | 1 | Next level accepts the request |
| mreq_addr | output | ADDR_W | Block index requested |
| mrsp_valid | input | 1 | Response data valid (in request order) |
| mrsp_data | input | DATA_W | Response block data |

## Verification
Three lookup patterns are compared. A strictly sequential walk through more blocks than the FIFO holds separates correct pop-and-refill and pointer wrap from a buffer that stalls or skips indices. A lookup for a block that is resident but not at the head shows whether only the head is compared, since a design that searches all entries would report a hit there. Lookups issued straight after a restart under a long memory latency tell apart proper stalling on a pending head, and the dropping of responses from an abandoned stream, from designs that return stale or missing data.

// File: rtl/pf_pkg.sv
package pf_pkg;
  typedef enum logic [1:0] {
    LK_IDLE = 2'd0,
    LK_WAIT = 2'd1,
    LK_HIT  = 2'd2,
    LK_MISS = 2'd3
  } lk_outcome_e;
endpackage

// File: rtl/pf_entry_store.sv
module pf_entry_store #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 64,
  parameter int DEPTH  = 4,
  parameter int PTR_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_all,
  input  logic              alloc_we,
  input  logic [PTR_W-1:0]  alloc_ptr,
  input  logic [ADDR_W-1:0] alloc_tag,
  input  logic              fill_we,
  input  logic [PTR_W-1:0]  fill_ptr,
  input  logic [DATA_W-1:0] fill_data,
  input  logic              pop,
  input  logic [PTR_W-1:0]  head_ptr,
  output logic [ADDR_W-1:0] head_tag,
  output logic              head_dvalid,
  output logic [DATA_W-1:0] head_data
);
  logic [ADDR_W-1:0] tag_q  [DEPTH];
  logic [DATA_W-1:0] data_q [DEPTH];
  logic [DEPTH-1:0]  dvalid_q;
  logic [DEPTH-1:0]  dvalid_n;

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_comb begin
      dvalid_n[g] = dvalid_q[g];
      if (clr_all)
        dvalid_n[g] = 1'b0;
      else if (alloc_we && (alloc_ptr == PTR_W'(g)))
        dvalid_n[g] = 1'b0;
      else if (fill_we && (fill_ptr == PTR_W'(g)))
        dvalid_n[g] = 1'b1;
      else if (pop && (head_ptr == PTR_W'(g)))
        dvalid_n[g] = 1'b0;
    end

    always_ff @(posedge clk) begin
      if (alloc_we && (alloc_ptr == PTR_W'(g))) tag_q[g] <= alloc_tag;
      if (fill_we && (fill_ptr == PTR_W'(g)))   data_q[g] <= fill_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dvalid_q <= '0;
    else        dvalid_q <= dvalid_n;
  end

  assign head_tag    = tag_q[head_ptr];
  assign head_dvalid = dvalid_q[head_ptr];
  assign head_data   = data_q[head_ptr];

  // R9
  fill_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill_we |-> !dvalid_q[fill_ptr]);
endmodule

// File: rtl/pf_req_ctrl.sv
module pf_req_ctrl #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 64,
  parameter int PTR_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  input  logic [ADDR_W-1:0] restart_addr,
  input  logic              room,
  input  logic [PTR_W-1:0]  tail_ptr,
  output logic              mreq_valid,
  input  logic              mreq_ready,
  output logic [ADDR_W-1:0] mreq_addr,
  input  logic              mrsp_valid,
  input  logic [DATA_W-1:0] mrsp_data,
  output logic              issue,
  output logic [ADDR_W-1:0] issue_tag,
  output logic              fill_we,
  output logic [PTR_W-1:0]  fill_ptr,
  output logic [DATA_W-1:0] fill_data
);
  logic              active_q, active_n;
  logic              outst_q, outst_n;
  logic              drop_q, drop_n;
  logic [ADDR_W-1:0] next_q, next_n;
  logic [PTR_W-1:0]  slot_q, slot_n;
  logic              fire, rsp_ok;

  assign mreq_valid = active_q && !outst_q && room;
  assign mreq_addr  = next_q;
  assign fire       = mreq_valid && mreq_ready;
  assign rsp_ok     = outst_q && mrsp_valid;
  assign issue      = fire && !restart;
  assign issue_tag  = next_q;
  assign fill_we    = rsp_ok && !drop_q && !restart;
  assign fill_ptr   = slot_q;
  assign fill_data  = mrsp_data;

  always_comb begin
    active_n = active_q;
    next_n   = next_q;
    outst_n  = outst_q;
    drop_n   = drop_q;
    slot_n   = slot_q;
    if (restart) begin
      active_n = 1'b1;
      next_n   = restart_addr + ADDR_W'(1);
    end else if (fire) begin
      next_n   = next_q + ADDR_W'(1);
    end
    if (fire) begin
      outst_n = 1'b1;
      slot_n  = tail_ptr;
    end else if (rsp_ok) begin
      outst_n = 1'b0;
    end
    if (rsp_ok)
      drop_n = 1'b0;
    if (restart && (fire || (outst_q && !mrsp_valid)))
      drop_n = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      next_q   <= '0;
      outst_q  <= 1'b0;
      drop_q   <= 1'b0;
      slot_q   <= '0;
    end else begin
      active_q <= active_n;
      next_q   <= next_n;
      outst_q  <= outst_n;
      drop_q   <= drop_n;
      slot_q   <= slot_n;
    end
  end

  // R8
  one_outstanding_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mreq_valid && mreq_ready) |=> !mreq_valid);
endmodule

// File: rtl/seq_stream_pf.sv
module seq_stream_pf #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 64,
  parameter int DEPTH  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lkp_valid,
  input  logic [ADDR_W-1:0] lkp_addr,
  output logic              lkp_done,
  output logic              lkp_hit,
  output logic [DATA_W-1:0] lkp_data,
  output logic              mreq_valid,
  input  logic              mreq_ready,
  output logic [ADDR_W-1:0] mreq_addr,
  input  logic              mrsp_valid,
  input  logic [DATA_W-1:0] mrsp_data
);
  import pf_pkg::*;

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [PTR_W-1:0]  head_q, head_n, tail_q, tail_n;
  logic [CNT_W-1:0]  count_q, count_n;
  logic              done_q, hit_q;
  logic [DATA_W-1:0] data_q;
  logic [ADDR_W-1:0] head_tag;
  logic              head_dvalid;
  logic [DATA_W-1:0] head_data;
  logic              issue, fill_we, room;
  logic [ADDR_W-1:0] issue_tag;
  logic [PTR_W-1:0]  fill_ptr;
  logic [DATA_W-1:0] fill_data;
  lk_outcome_e       outcome;
  logic              pop, restart;

  assign room = (count_q < CNT_W'(DEPTH));

  always_comb begin
    outcome = LK_IDLE;
    if (lkp_valid && !done_q) begin
      if ((count_q != '0) && (head_tag == lkp_addr))
        outcome = head_dvalid ? LK_HIT : LK_WAIT;
      else
        outcome = LK_MISS;
    end
  end

  assign pop     = (outcome == LK_HIT);
  assign restart = (outcome == LK_MISS);

  always_comb begin
    head_n  = head_q;
    tail_n  = tail_q;
    count_n = count_q;
    if (restart) begin
      tail_n  = head_q;
      count_n = '0;
    end else begin
      if (pop)   head_n = head_q + PTR_W'(1);
      if (issue) tail_n = tail_q + PTR_W'(1);
      count_n = count_q + CNT_W'(issue) - CNT_W'(pop);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q  <= '0;
      tail_q  <= '0;
      count_q <= '0;
      done_q  <= 1'b0;
      hit_q   <= 1'b0;
    end else begin
      head_q  <= head_n;
      tail_q  <= tail_n;
      count_q <= count_n;
      done_q  <= pop || restart;
      hit_q   <= pop;
    end
  end

  always_ff @(posedge clk) begin
    if (pop) data_q <= head_data;
  end

  assign lkp_done = done_q;
  assign lkp_hit  = hit_q;
  assign lkp_data = data_q;

  pf_entry_store #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH), .PTR_W(PTR_W)
  ) store_i (
    .clk(clk), .rst_n(rst_n), .clr_all(restart),
    .alloc_we(issue), .alloc_ptr(tail_q), .alloc_tag(issue_tag),
    .fill_we(fill_we), .fill_ptr(fill_ptr), .fill_data(fill_data),
    .pop(pop), .head_ptr(head_q),
    .head_tag(head_tag), .head_dvalid(head_dvalid), .head_data(head_data)
  );

  pf_req_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PTR_W(PTR_W)
  ) req_i (
    .clk(clk), .rst_n(rst_n), .restart(restart), .restart_addr(lkp_addr),
    .room(room), .tail_ptr(tail_q),
    .mreq_valid(mreq_valid), .mreq_ready(mreq_ready), .mreq_addr(mreq_addr),
    .mrsp_valid(mrsp_valid), .mrsp_data(mrsp_data),
    .issue(issue), .issue_tag(issue_tag),
    .fill_we(fill_we), .fill_ptr(fill_ptr), .fill_data(fill_data)
  );

  // R3
  occupancy_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count_q <= CNT_W'(DEPTH));

  // R2
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lkp_done |=> !lkp_done);

  // R2
  done_after_lookup_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lkp_done) |-> $past(lkp_valid));

  // R7
  hit_data_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lkp_done && lkp_hit) |-> $past(head_dvalid));
endmodule

// File: tb/seq_stream_pf_tb_top.sv
module seq_stream_pf_tb_top;
  localparam int AW = 16;
  localparam int DW = 64;
  localparam int DEPTH = 4;

  logic          clk, rst_n;
  logic          lkp_valid;
  logic [AW-1:0] lkp_addr;
  logic          lkp_done, lkp_hit;
  logic [DW-1:0] lkp_data;
  logic          mreq_valid, mreq_ready;
  logic [AW-1:0] mreq_addr;
  logic          mrsp_valid;
  logic [DW-1:0] mrsp_data;

  int checks = 0;
  int fails  = 0;
  int mem_lat = 2;

  typedef struct {
    logic          hit;
    logic [DW-1:0] data;
    string         req;
  } exp_t;

  exp_t          exp_q[$];
  logic [AW-1:0] reqlog[$];

  seq_stream_pf #(.ADDR_W(AW), .DATA_W(DW), .DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .lkp_valid(lkp_valid), .lkp_addr(lkp_addr),
    .lkp_done(lkp_done), .lkp_hit(lkp_hit), .lkp_data(lkp_data),
    .mreq_valid(mreq_valid), .mreq_ready(mreq_ready), .mreq_addr(mreq_addr),
    .mrsp_valid(mrsp_valid), .mrsp_data(mrsp_data)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [DW-1:0] blk(input logic [AW-1:0] a);
    return {a ^ 16'hA5C3, ~a, a, a * 16'd7};
  endfunction

  task automatic chk(input bit ok, input string rq, input logic [DW-1:0] act,
                     input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %h expected %h", rq, act, exp);
    end
  endtask

  // memory responder: one request in flight, fixed latency
  logic          busy = 1'b0;
  int            cnt = 0;
  logic [AW-1:0] pend;
  always @(negedge clk) begin
    mrsp_valid <= 1'b0;
    if (busy) begin
      if (cnt == 1) begin
        mrsp_valid <= 1'b1;
        mrsp_data  <= blk(pend);
        busy       <= 1'b0;
      end else begin
        cnt <= cnt - 1;
      end
    end
    if (rst_n && mreq_valid) begin
      if (busy) chk(1'b0, "R8 second request while busy", 64'(mreq_addr), 64'(pend));
      reqlog.push_back(mreq_addr);
      pend <= mreq_addr;
      cnt  <= mem_lat;
      busy <= 1'b1;
    end
  end

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && lkp_done) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R2 unexpected completion", 64'(lkp_hit), 64'd0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        chk(lkp_hit == e.hit, {e.req, " hit flag"}, 64'(lkp_hit), 64'(e.hit));
        if (e.hit) chk(lkp_data == e.data, {e.req, " data"}, lkp_data, e.data);
      end
    end
  end

  task automatic lookup(input logic [AW-1:0] a, input logic exp_hit,
                        input string rq, output int lat);
    exp_t e;
    e.hit = exp_hit; e.data = blk(a); e.req = rq;
    exp_q.push_back(e);
    lkp_addr  = a;
    lkp_valid = 1'b1;
    lat = 0;
    do begin
      @(negedge clk);
      lat++;
    end while (!lkp_done);
    lkp_valid = 1'b0;
    @(negedge clk);
  endtask

  task automatic check_tail(input logic [AW-1:0] base, input string rq);
    int n;
    n = reqlog.size();
    for (int i = 0; i < DEPTH; i++) begin
      if (n < DEPTH) chk(1'b0, {rq, " too few requests"}, 64'(n), 64'(DEPTH));
      else chk(reqlog[n-DEPTH+i] == base + AW'(i), rq,
               64'(reqlog[n-DEPTH+i]), 64'(base + AW'(i)));
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    int lat, n0;
    rst_n = 1'b0; lkp_valid = 1'b0; lkp_addr = '0; mreq_ready = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);
    // R1: idle after reset
    chk(!mreq_valid, "R1 no request after reset", 64'(mreq_valid), 64'd0);
    chk(reqlog.size() == 0, "R1 request log empty", 64'(reqlog.size()), 64'd0);
    chk(!lkp_done, "R1 no completion after reset", 64'(lkp_done), 64'd0);

    // R2: empty buffer miss
    lookup(16'd100, 1'b0, "R2 empty miss", lat);
    repeat (60) @(negedge clk);
    // R3: stream b+1..b+DEPTH, then quiet
    check_tail(16'd101, "R3 initial stream");
    n0 = reqlog.size();
    repeat (30) @(negedge clk);
    chk(reqlog.size() == n0, "R3 no request when full", 64'(reqlog.size()), 64'(n0));

    // R4: resident head hit, one-cycle latency
    lookup(16'd101, 1'b1, "R4 head hit", lat);
    chk(lat == 1, "R4 hit latency", 64'(lat), 64'd1);
    lookup(16'd102, 1'b1, "R4 second head hit", lat);
    repeat (40) @(negedge clk);
    // R5: each pop refilled with next index
    check_tail(16'd103, "R5 refill after pops");

    // R6: resident but not head -> miss and restart
    lookup(16'd105, 1'b0, "R6 non-head match", lat);
    repeat (60) @(negedge clk);
    check_tail(16'd106, "R6 restart stream");

    // R5: long sequential walk across pointer wrap
    for (int i = 0; i < 20; i++) lookup(AW'(106 + i), 1'b1, "R5 sequential walk", lat);
    repeat (60) @(negedge clk);
    check_tail(16'd126, "R5 stream after wrap");

    // R7: head pending stalls
    mem_lat = 20;
    lookup(16'd300, 1'b0, "R7 restart", lat);
    lookup(16'd301, 1'b1, "R7 stalled hit", lat);
    chk(lat >= 10, "R7 hit held for data", 64'(lat), 64'd10);
    repeat (200) @(negedge clk);

    // R9: abandon a stream with a request in flight
    lookup(16'd500, 1'b0, "R9 first stream", lat);
    repeat (4) @(negedge clk);
    lookup(16'd700, 1'b0, "R9 abandon", lat);
    repeat (200) @(negedge clk);
    for (int i = 1; i <= 5; i++) lookup(AW'(700 + i), 1'b1, "R9 fresh data", lat);
    mem_lat = 2;
    repeat (60) @(negedge clk);
    check_tail(16'd706, "R9 stream after abandon");
    chk(exp_q.size() == 0, "R2 all lookups completed", 64'(exp_q.size()), 64'd0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule